// File: doc/BRIEF.md
# Three-Level Dual-Bridge Switching-State Generator

This block produces the switching states for two three-level full bridges, an a-side and a b-side, each built from two legs. Every leg can tie its output node to the top, neutral or bottom point of its dc link. A phase accumulator advances once per clock by a programmable step and wraps once per switching period. The a-side uses the accumulator phase directly. The b-side uses the same phase displaced by a signed shift. A positive shift makes the b-side lag the a-side, which moves power from the a-side to the b-side. A negative shift reverses the direction.

Each side takes four angles: a first and a second inner angle, which place the edges in the rising part of each half period, and a first and a second outer angle, which place the falling edges. All of them are unsigned fractions of a full turn. Together they form a bridge voltage with up to five levels that is odd-symmetric about the start of the period. When the inner and outer angles are equal, the waveform also has quarter-wave symmetry. New angles, shift and gap values take effect only at a period boundary.

Every leg level change passes through an interval where all of the leg's switches are off. The length of that interval is set in clock cycles. A synchronous enable, when low, holds the phase at zero and steers all legs to neutral.

Top module: `tlb_switch_gen`

## Requirements
- R1: While reset is active and after it is released with enable low, `phase` is 0 and every leg output is `3'b010`. The one-hot encoding is bit 2 = top, bit 1 = neutral, bit 0 = bottom, and `3'b000` means all off.
- R2: With enable high, `phase` increases by `step` on every clock, modulo 2^16. A wrap (carry out of bit 15) marks a new period. With enable low, `phase` is held at 0.
- R3: With half turn H = 32768 and full turn F = 65536, the first leg of a side requests top for theta in [i1, H−o1) and bottom for theta in [H+o1, F−i1). The second leg requests bottom for theta in [i2, H−o2) and top for theta in [H+o2, F−i2). Any other theta gives neutral.
- R4: The a-side theta is `phase`. The b-side theta is (`phase` − shift) mod 2^16, where the shift is a two's-complement value.
- R5: A shift above +16384 is used as +16384, and a shift below −16384 is used as −16384.
- R6: Each first angle is limited to 16384 (a quarter turn). Each second angle is first raised to at least its first angle plus `gap`, then limited to 16384.
- R7: Angles, shift and gap are captured on the clock edge of a wrap, or on any edge while enable is low. Changes between those points have no effect on the legs.
- R8: When a leg's requested level differs from its driven level, the leg outputs `3'b000` for exactly `dead`+1 cycles. It then drives the level requested on the final edge of that interval. A driven level never changes straight to another driven level.
- R9: With enable low, every leg requests neutral.
- R10: Each leg output has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous run enable |
| step | input | 16 | Phase increment per clock |
| a_in1 | input | 16 | a-side first inner angle |
| a_in2 | input | 16 | a-side second inner angle |
| a_out1 | input | 16 | a-side first outer angle |
| a_out2 | input | 16 | a-side second outer angle |
| b_in1 | input | 16 | b-side first inner angle |
| b_in2 | input | 16 | b-side second inner angle |
| b_out1 | input | 16 | b-side first outer angle |
| b_out2 | input | 16 | b-side second outer angle |
| phi | input | 16 | Signed inter-bridge shift, fraction of a turn |
| gap | input | 16 | Minimum second-minus-first angle margin |
| dead | input | 8 | All-off interval length minus one, in cycles |
| phase | output | 16 | Current a-side phase |
| a_leg1 | output | 3 | a-side first leg one-hot state |
| a_leg2 | output | 3 | a-side second leg one-hot state |
| b_leg1 | output | 3 | b-side first leg one-hot state |
| b_leg2 | output | 3 | b-side second leg one-hot state |

## Verification
The hardest case to reach is a change of parameters partway through a period. Only such a change shows whether the new values stay unused until the next wrap. The stimulus rewrites angles and shift at arbitrary cycles, and it uses a step that does not divide the turn evenly, so wraps fall at irregular phases.

A second hard case is a first angle of zero, where a leg is asked to go from bottom straight to top across the wrap. Zero-valued angles, together with dead intervals of 0 and 7 cycles, force this case, and the all-off interval can be seen at the pins.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PH_W = 16;
  typedef logic [PH_W-1:0] ang_t;

  localparam logic [PH_W:0] QTR_X  = (PH_W+1)'(1) << (PH_W-2);
  localparam logic [PH_W:0] HALF_X = (PH_W+1)'(1) << (PH_W-1);
  localparam logic [PH_W:0] FULL_X = (PH_W+1)'(1) << PH_W;
  localparam ang_t QTR_A  = ang_t'(QTR_X);
  localparam ang_t NQTR_A = ang_t'(FULL_X - QTR_X);

  typedef enum logic [1:0] {LV_BOT = 2'd0, LV_MID = 2'd1, LV_TOP = 2'd2} lvl_e;

  typedef struct packed {
    ang_t a_in1;
    ang_t a_in2;
    ang_t a_out1;
    ang_t a_out2;
  } side_ang_t;

  // limit an angle to a quarter turn
  function automatic ang_t sat_qtr(input logic [PH_W:0] v);
    return (v > QTR_X) ? QTR_A : v[PH_W-1:0];
  endfunction

  // raise the second angle to first+gap, then limit
  function automatic ang_t widen_second(input ang_t first, input ang_t second, input ang_t gap);
    logic [PH_W:0] floor_v;
    logic [PH_W:0] s;
    floor_v = {1'b0, first} + {1'b0, gap};
    s = {1'b0, second};
    if (s < floor_v) s = floor_v;
    return sat_qtr(s);
  endfunction

  // saturate a signed shift to +/- a quarter turn
  function automatic ang_t clamp_phi(input ang_t p);
    logic signed [PH_W-1:0] s;
    s = signed'(p);
    if (s > signed'(QTR_A)) return QTR_A;
    if (s < signed'(NQTR_A)) return NQTR_A;
    return p;
  endfunction

  // requested level of one leg at phase th
  function automatic lvl_e leg_level(input ang_t th, input ang_t a, input ang_t o, input logic lead);
    logic [PH_W:0] t;
    logic pos, neg;
    t = {1'b0, th};
    pos = (t >= {1'b0, a}) && (t < HALF_X - {1'b0, o});
    neg = (t >= HALF_X + {1'b0, o}) && (t < FULL_X - {1'b0, a});
    if (pos) return lead ? LV_TOP : LV_BOT;
    if (neg) return lead ? LV_BOT : LV_TOP;
    return LV_MID;
  endfunction

  function automatic logic [2:0] lvl_onehot(input lvl_e l);
    case (l)
      LV_TOP:  return 3'b100;
      LV_BOT:  return 3'b001;
      default: return 3'b010;
    endcase
  endfunction
endpackage

// File: rtl/tlb_phase.sv
module tlb_phase
  import tlb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  ang_t step,
  output ang_t phase,
  output logic wrap
);
  logic [PH_W:0] sum;

  assign sum  = {1'b0, phase} + {1'b0, step};
  assign wrap = en & sum[PH_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase <= '0;
    else if (!en) phase <= '0;
    else          phase <= sum[PH_W-1:0];
  end
endmodule

// File: rtl/tlb_angle_bank.sv
module tlb_angle_bank
  import tlb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  side_ang_t raw,
  input  ang_t      gap,
  output side_ang_t eff
);
  side_ang_t cand;

  always_comb begin
    cand.a_in1  = sat_qtr({1'b0, raw.a_in1});
    cand.a_out1 = sat_qtr({1'b0, raw.a_out1});
    cand.a_in2  = widen_second(cand.a_in1, raw.a_in2, gap);
    cand.a_out2 = widen_second(cand.a_out1, raw.a_out2, gap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    eff <= '0;
    else if (load) eff <= cand;
  end
endmodule

// File: rtl/tlb_leg_drv.sv
module tlb_leg_drv
  import tlb_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  lvl_e            want,
  input  logic [DT_W-1:0] dead,
  output logic [2:0]      drive
);
  lvl_e            held;
  logic            blank;
  logic [DT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= LV_MID;
      blank <= 1'b0;
      cnt   <= '0;
    end else if (blank) begin
      if (cnt == '0) begin
        held  <= want;
        blank <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (want != held) begin
      blank <= 1'b1;
      cnt   <= dead;
    end
  end

  assign drive = blank ? 3'b000 : lvl_onehot(held);
endmodule

// File: rtl/tlb_switch_gen.sv
module tlb_switch_gen
  import tlb_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [PH_W-1:0]     step,
  input  logic [PH_W-1:0]     a_in1,
  input  logic [PH_W-1:0]     a_in2,
  input  logic [PH_W-1:0]     a_out1,
  input  logic [PH_W-1:0]     a_out2,
  input  logic [PH_W-1:0]     b_in1,
  input  logic [PH_W-1:0]     b_in2,
  input  logic [PH_W-1:0]     b_out1,
  input  logic [PH_W-1:0]     b_out2,
  input  logic [PH_W-1:0]     phi,
  input  logic [PH_W-1:0]     gap,
  input  logic [DT_W-1:0]     dead,
  output logic [PH_W-1:0]     phase,
  output logic [2:0]          a_leg1,
  output logic [2:0]          a_leg2,
  output logic [2:0]          b_leg1,
  output logic [2:0]          b_leg2
);
  localparam int N_SIDE = 2;
  localparam int N_LEG  = 2 * N_SIDE;

  logic      wrap;
  logic      load;
  ang_t      phi_eff;
  ang_t      theta [N_SIDE];
  side_ang_t raw   [N_SIDE];
  side_ang_t eff   [N_SIDE];
  lvl_e      want  [N_LEG];
  logic [2:0] drv  [N_LEG];

  tlb_phase u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .step  (step),
    .phase (phase),
    .wrap  (wrap)
  );

  assign load   = wrap | ~en;
  assign raw[0] = {a_in1, a_in2, a_out1, a_out2};
  assign raw[1] = {b_in1, b_in2, b_out1, b_out2};

  for (genvar s = 0; s < N_SIDE; s++) begin : g_side
    tlb_angle_bank u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .raw   (raw[s]),
      .gap   (gap),
      .eff   (eff[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phi_eff <= '0;
    else if (load) phi_eff <= clamp_phi(phi);
  end

  assign theta[0] = phase;
  assign theta[1] = phase - phi_eff;

  for (genvar k = 0; k < N_LEG; k++) begin : g_leg
    localparam int S = k / 2;
    lvl_e lv;
    if ((k % 2) == 0) begin : g_first
      assign lv = leg_level(theta[S], eff[S].a_in1, eff[S].a_out1, 1'b1);
    end else begin : g_second
      assign lv = leg_level(theta[S], eff[S].a_in2, eff[S].a_out2, 1'b0);
    end
    assign want[k] = en ? lv : LV_MID;

    tlb_leg_drv #(.DT_W(DT_W)) u_leg (
      .clk   (clk),
      .rst_n (rst_n),
      .want  (want[k]),
      .dead  (dead),
      .drive (drv[k])
    );
  end

  assign a_leg1 = drv[0];
  assign a_leg2 = drv[1];
  assign b_leg1 = drv[2];
  assign b_leg2 = drv[3];
endmodule

// File: rtl/tlb_switch_gen_chk.sv
module tlb_switch_gen_chk
  import tlb_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input ang_t       step,
  input ang_t       phase,
  input logic       wrap,
  input ang_t       phi_eff,
  input logic [2:0] a_leg1,
  input logic [2:0] a_leg2,
  input logic [2:0] b_leg1,
  input logic [2:0] b_leg2
);
  logic [3:0][2:0] legs;
  assign legs = {b_leg2, b_leg1, a_leg2, a_leg1};

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(en)) |-> (phase == ang_t'($past(phase) + $past(step))));

  assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(en)) |-> (phase == '0));

  assert_shift_shadow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(en) && !$past(wrap)) |-> $stable(phi_eff));

  for (genvar k = 0; k < 4; k++) begin : g_leg_chk
    assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(legs[k]));

    assert_blank_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (legs[k] != 3'b000 && $past(legs[k]) != 3'b000) |-> (legs[k] == $past(legs[k])));

    assert_no_rail_jump_R8: assert property (@(posedge clk) disable iff (!rst_n)
      legs[k][0] |-> !$past(legs[k][2]));
  end
endmodule

bind tlb_switch_gen tlb_switch_gen_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .step    (step),
  .phase   (phase),
  .wrap    (wrap),
  .phi_eff (phi_eff),
  .a_leg1  (a_leg1),
  .a_leg2  (a_leg2),
  .b_leg1  (b_leg1),
  .b_leg2  (b_leg2)
);

// File: tb/tlb_switch_gen_tb_top.sv
module tlb_switch_gen_tb_top;
  localparam int Q = 16384;
  localparam int H = 32768;
  localparam int F = 65536;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [15:0] step = 16'd512;
  logic [15:0] a_in1 = 0, a_in2 = 0, a_out1 = 0, a_out2 = 0;
  logic [15:0] b_in1 = 0, b_in2 = 0, b_out1 = 0, b_out2 = 0;
  logic [15:0] phi = 0, gap = 0;
  logic [7:0]  dead = 8'd2;
  logic [15:0] phase;
  logic [2:0]  a_leg1, a_leg2, b_leg1, b_leg2;

  always #5 clk = ~clk;

  tlb_switch_gen dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .step(step),
    .a_in1(a_in1), .a_in2(a_in2), .a_out1(a_out1), .a_out2(a_out2),
    .b_in1(b_in1), .b_in2(b_in2), .b_out1(b_out1), .b_out2(b_out2),
    .phi(phi), .gap(gap), .dead(dead), .phase(phase),
    .a_leg1(a_leg1), .a_leg2(a_leg2), .b_leg1(b_leg1), .b_leg2(b_leg2)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  int m_ph;
  int s_i1 [2], s_i2 [2], s_o1 [2], s_o2 [2];
  int s_phi;
  int m_lvl [4];   // 0 bottom, 1 neutral, 2 top
  bit m_off [4];
  int m_cnt [4];

  function automatic int lim(int v);
    return (v > Q) ? Q : v;
  endfunction

  // requested level from the window rules
  function automatic int req_of(int th, int a, int o, bit first);
    bit up, dn;
    up = (th >= a) && (th < H - o);
    dn = (th >= H + o) && (th < F - a);
    if (up) return first ? 2 : 0;
    if (dn) return first ? 0 : 2;
    return 1;
  endfunction

  function automatic logic [2:0] pins_of(int l, bit off);
    if (off) return 3'b000;
    return (l == 2) ? 3'b100 : (l == 0) ? 3'b001 : 3'b010;
  endfunction

  task automatic load_shadow();
    int raw [2][4];
    int p;
    raw[0] = '{int'(a_in1), int'(a_in2), int'(a_out1), int'(a_out2)};
    raw[1] = '{int'(b_in1), int'(b_in2), int'(b_out1), int'(b_out2)};
    for (int s = 0; s < 2; s++) begin
      s_i1[s] = lim(raw[s][0]);
      s_o1[s] = lim(raw[s][2]);
      s_i2[s] = lim((raw[s][1] < s_i1[s] + int'(gap)) ? s_i1[s] + int'(gap) : raw[s][1]);
      s_o2[s] = lim((raw[s][3] < s_o1[s] + int'(gap)) ? s_o1[s] + int'(gap) : raw[s][3]);
    end
    p = int'($signed(phi));
    if (p > Q) p = Q;
    if (p < -Q) p = -Q;
    s_phi = p;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0;
      s_phi = 0;
      for (int s = 0; s < 2; s++) begin
        s_i1[s] = 0; s_i2[s] = 0; s_o1[s] = 0; s_o2[s] = 0;
      end
      for (int k = 0; k < 4; k++) begin
        m_lvl[k] = 1; m_off[k] = 0; m_cnt[k] = 0;
      end
    end else begin
      int th [2];
      int rq [4];
      int nx;
      th[0] = m_ph;
      th[1] = (m_ph - s_phi + 2 * F) % F;
      for (int k = 0; k < 4; k++) begin
        int s;
        s = k / 2;
        if (!en)            rq[k] = 1;
        else if (k % 2 == 0) rq[k] = req_of(th[s], s_i1[s], s_o1[s], 1'b1);
        else                 rq[k] = req_of(th[s], s_i2[s], s_o2[s], 1'b0);
      end
      for (int k = 0; k < 4; k++) begin
        if (m_off[k]) begin
          if (m_cnt[k] == 0) begin
            m_lvl[k] = rq[k];
            m_off[k] = 0;
          end else m_cnt[k] = m_cnt[k] - 1;
        end else if (rq[k] != m_lvl[k]) begin
          m_off[k] = 1;
          m_cnt[k] = int'(dead);
        end
      end
      nx = m_ph + int'(step);
      if (!en) begin
        m_ph = 0;
        load_shadow();
      end else begin
        m_ph = nx % F;
        if (nx >= F) load_shadow();
      end
    end
  end

  task automatic one(string tag, string what, logic [15:0] got, logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %0h expected %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    logic [2:0] act [4];
    act = '{a_leg1, a_leg2, b_leg1, b_leg2};
    one(tag, "phase", phase, 16'(m_ph));
    for (int k = 0; k < 4; k++) begin
      one(tag, $sformatf("leg%0d", k), {13'd0, act[k]}, {13'd0, pins_of(m_lvl[k], m_off[k])});
      // R10: never two levels at once
      one("R10", $sformatf("leg%0d ones", k), 16'($countones(act[k]) > 1), 16'd0);
    end
  endtask

  task automatic run(int cycles, string tag);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      check_all(tag);
    end
  endtask

  task automatic set_a(int i1, int i2, int o1, int o2);
    a_in1 = 16'(i1); a_in2 = 16'(i2); a_out1 = 16'(o1); a_out2 = 16'(o2);
  endtask

  task automatic set_b(int i1, int i2, int o1, int o2);
    b_in1 = 16'(i1); b_in2 = 16'(i2); b_out1 = 16'(o1); b_out2 = 16'(o2);
  endtask

  initial begin
    set_a(4000, 10000, 4000, 10000);
    set_b(3000, 12000, 3000, 12000);
    phi = 16'(5000);
    gap = 16'd100;
    repeat (3) @(negedge clk);
    // R1: reset state
    one("R1", "phase rst", phase, 16'd0);
    one("R1", "a_leg1 rst", {13'd0, a_leg1}, 16'h2);
    one("R1", "b_leg2 rst", {13'd0, b_leg2}, 16'h2);
    rst_n = 1'b1;
    run(4, "R1");
    en = 1'b1;
    // quarter-wave pattern, positive shift
    run(400, "R3");
    // unequal inner/outer, negative shift
    set_a(2000, 9000, 6000, 14000);
    set_b(1000, 5000, 7000, 15000);
    phi = 16'(-7000);
    run(400, "R4");
    // shift beyond the limit, both signs
    phi = 16'(30000);
    run(300, "R5");
    phi = 16'(-30000);
    run(300, "R5");
    // second angle pushed by gap, angles above a quarter turn
    gap = 16'd1500;
    set_a(8000, 8100, 20000, 3000);
    set_b(17000, 0, 500, 40000);
    run(400, "R6");
    // mid-period rewrites
    gap = 16'd50;
    run(37, "R7");
    set_a(1234, 5678, 2345, 6789);
    phi = 16'(3333);
    run(61, "R7");
    set_b(9000, 9500, 100, 16000);
    run(300, "R7");
    // zero first angles: bottom-to-top request across the wrap
    set_a(0, 6000, 0, 6000);
    set_b(0, 0, 0, 16384);
    dead = 8'd0;
    run(300, "R8");
    dead = 8'd7;
    run(300, "R8");
    // enable low mid-run
    dead = 8'd3;
    run(50, "R8");
    en = 1'b0;
    run(30, "R9");
    en = 1'b1;
    // non-dividing step
    step = 16'd1000;
    set_a(5000, 12000, 4000, 13000);
    run(400, "R2");
    step = 16'd65000;
    run(60, "R2");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1 got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule